// File: doc/BRIEF.md
# Sub-Word Load/Store Byte-Lane Aligner

This block sits between a load/store unit and a memory that is 64 bits wide and has one write enable per byte lane. It takes a byte address, an access size of 1, 2, 4 or 8 bytes, and a byte-swap flag.

For a store, it produces three things:
- the index of the memory word;
- the byte-lane write enables;
- the store data moved into the lanes the access covers.

For a load, it takes the word read from memory and returns the addressed bytes. Those bytes are shifted down to bit 0 and zero-extended.

Lanes are little-endian. The low three address bits give the lane of the first byte, and the byte at offset 0 sits in bits 7:0. A big-endian access does not rearrange the stored word. It only reverses the order of the bytes inside the access width of the load or store data. An access whose bytes would cross an 8-byte boundary is flagged and has no effect.

By default, all outputs pass through one register stage. A parameter can remove that stage and make the outputs combinational.

Top module: `lane_aligner`

## Requirements
- R1: `word_idx_o` equals the byte address shifted right by 3, so it drops address bits 2:0.
- R2: For a store request whose bytes fit in the word, `wr_en_o` has ones in lanes `off` through `off+n-1` and zeros in all other lanes. Here `off` is address bits 2:0 and `n` is the access size in bytes.
- R3: Store data byte k goes to lane `off+k`, so the shift is `off*8` bits counted from bit 0. Every lane whose enable is low carries zero. A 1-byte store of 0xEE to address 0x9 enables only lane 1, with data 0x000000000000EE00. Merged into the word 0xABCDEF0187654321, this gives 0xABCDEF018765EE21.
- R4: With `swap_i` high, the low `n` store bytes are placed in reverse order: byte `n-1-k` lands in lane `off+k`. Bytes outside the access are not moved.
- R5: `ld_data_o` equals `(ld_word_i >> off*8)` masked to the low `n*8` bits, with all higher bits zero.
- R6: With `swap_i` high, the extracted load bytes are reversed within `n` bytes after extraction. Bits above `n*8` stay zero.
- R7: When `off + n > 8`, `misalign_o` is 1, and `wr_en_o`, `wr_data_o` and `ld_data_o` are all zero. Otherwise `misalign_o` is 0.
- R8: `size_i` encodes the access size: 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes and 11 is 8 bytes.
- R9: With the default register stage, outputs reflect the inputs sampled at the previous rising clock edge. Holding `rst_n` low clears every output to zero.
- R10: With `st_req_i` low, `wr_en_o` and `wr_data_o` are zero. The load result and word index are still produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 32 | Byte address of the access |
| size_i | input | 2 | Access size code (00=1, 01=2, 10=4, 11=8 bytes) |
| swap_i | input | 1 | Reverse byte order within the access width |
| st_req_i | input | 1 | Current access is a store |
| st_data_i | input | 64 | Store data, right-justified |
| ld_word_i | input | 64 | Word read from memory |
| word_idx_o | output | 29 | Memory word index |
| wr_en_o | output | 8 | Per-lane byte write enables |
| wr_data_o | output | 64 | Store data placed in lanes |
| ld_data_o | output | 64 | Extracted, zero-extended load data |
| misalign_o | output | 1 | Access crosses the 8-byte boundary |

## Verification
The directed cases cover the following:
- A single byte stored at address 0x9. This catches a shift measured from the wrong end of the word, which would put 0xEE in lane 6 instead of lane 1.
- Swapped and unswapped 4-byte accesses. These distinguish reversal within the access width from reversal of the whole word.
- Accesses that end exactly at the boundary and accesses that cross it by one byte. These pin the comparison used for the misalignment check.

Seeded random vectors mix every size, offset, swap setting and store request. They show that the lane mask, data placement and load extraction agree for every size and offset, not only for the directed values.

// File: rtl/lane_pkg.sv
package lane_pkg;
    localparam int BYTE_BITS = 8;

    // Access size code; each step doubles the byte count.
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lane_enable_gen.sv
module lane_enable_gen #(
    parameter int WORD_BYTES = 8,
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int SIZE_W    = $clog2(OFF_W + 1)
) (
    input  logic [OFF_W-1:0]      off_i,
    input  logic [SIZE_W-1:0]     size_i,
    input  logic                  st_req_i,
    output logic                  misalign_o,
    output logic [WORD_BYTES-1:0] wr_en_o
);
    logic [2*WORD_BYTES-1:0] span_d;
    logic [2*WORD_BYTES-1:0] shifted_d;
    int                      n_bytes_d;
    int                      end_d;

    always_comb begin
        n_bytes_d  = 1 << size_i;
        end_d      = int'(off_i) + n_bytes_d;
        misalign_o = end_d > WORD_BYTES;
        span_d     = ((2*WORD_BYTES)'(1) << n_bytes_d) - (2*WORD_BYTES)'(1);
        shifted_d  = span_d << off_i;
        wr_en_o    = (misalign_o || !st_req_i) ? '0 : shifted_d[WORD_BYTES-1:0];
    end
endmodule

// File: rtl/lane_trim_swap.sv
module lane_trim_swap #(
    parameter int WORD_BYTES = 8,
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int SIZE_W    = $clog2(OFF_W + 1),
    localparam int DATA_W    = WORD_BYTES * lane_pkg::BYTE_BITS
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              swap_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int BB = lane_pkg::BYTE_BITS;

    int n_bytes_d;

    // Keep the low n bytes; optionally mirror them inside those n bytes.
    always_comb begin
        n_bytes_d = 1 << size_i;
        data_o    = '0;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (i < n_bytes_d) begin
                if (swap_i)
                    data_o[BB*i +: BB] = data_i[BB*(n_bytes_d-1-i) +: BB];
                else
                    data_o[BB*i +: BB] = data_i[BB*i +: BB];
            end
        end
    end
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 8,
    parameter bit OUT_REG    = 1'b1,
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int SIZE_W    = $clog2(OFF_W + 1),
    localparam int DATA_W    = WORD_BYTES * lane_pkg::BYTE_BITS,
    localparam int IDX_W     = ADDR_W - OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [SIZE_W-1:0]     size_i,
    input  logic                  swap_i,
    input  logic                  st_req_i,
    input  logic [DATA_W-1:0]     st_data_i,
    input  logic [DATA_W-1:0]     ld_word_i,
    output logic [IDX_W-1:0]      word_idx_o,
    output logic [WORD_BYTES-1:0] wr_en_o,
    output logic [DATA_W-1:0]     wr_data_o,
    output logic [DATA_W-1:0]     ld_data_o,
    output logic                  misalign_o
);
    localparam int BB = lane_pkg::BYTE_BITS;

    typedef struct packed {
        logic [IDX_W-1:0]      word_idx;
        logic [WORD_BYTES-1:0] wr_en;
        logic [DATA_W-1:0]     wr_data;
        logic [DATA_W-1:0]     ld_data;
        logic                  misalign;
    } res_t;

    function automatic logic [DATA_W-1:0] lane_expand(input logic [WORD_BYTES-1:0] en);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < WORD_BYTES; b++) m[BB*b +: BB] = {BB{en[b]}};
        return m;
    endfunction

    logic [OFF_W-1:0]      off_d;
    logic [OFF_W+2:0]      shamt_d;
    logic                  misalign_d;
    logic [WORD_BYTES-1:0] en_d;
    logic [DATA_W-1:0]     st_trim_d;
    logic [DATA_W-1:0]     ld_shift_d;
    logic [DATA_W-1:0]     ld_trim_d;
    res_t                  res_d;
    res_t                  res_q;

    assign off_d      = addr_i[OFF_W-1:0];
    assign shamt_d    = {off_d, 3'b000};
    assign ld_shift_d = ld_word_i >> shamt_d;

    lane_enable_gen #(.WORD_BYTES(WORD_BYTES)) u_en (
        .off_i      (off_d),
        .size_i     (size_i),
        .st_req_i   (st_req_i),
        .misalign_o (misalign_d),
        .wr_en_o    (en_d)
    );

    lane_trim_swap #(.WORD_BYTES(WORD_BYTES)) u_st_swap (
        .data_i (st_data_i),
        .size_i (size_i),
        .swap_i (swap_i),
        .data_o (st_trim_d)
    );

    lane_trim_swap #(.WORD_BYTES(WORD_BYTES)) u_ld_swap (
        .data_i (ld_shift_d),
        .size_i (size_i),
        .swap_i (swap_i),
        .data_o (ld_trim_d)
    );

    always_comb begin
        res_d          = '0;
        res_d.word_idx = addr_i[ADDR_W-1:OFF_W];
        res_d.misalign = misalign_d;
        res_d.wr_en    = en_d;
        res_d.wr_data  = (st_trim_d << shamt_d) & lane_expand(en_d);
        res_d.ld_data  = misalign_d ? '0 : ld_trim_d;
    end

    generate
        if (OUT_REG) begin : g_reg
            logic primed_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_q    <= '0;
                    primed_q <= 1'b0;
                end else begin
                    res_q    <= res_d;
                    primed_q <= 1'b1;
                end
            end

            // R1
            idx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                primed_q |-> word_idx_o == $past(addr_i[ADDR_W-1:OFF_W]));

            // R10
            load_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (primed_q && !$past(st_req_i)) |-> (wr_en_o == '0 && wr_data_o == '0));
        end else begin : g_comb
            assign res_q = res_d;
        end
    endgenerate

    assign word_idx_o = res_q.word_idx;
    assign wr_en_o    = res_q.wr_en;
    assign wr_data_o  = res_q.wr_data;
    assign ld_data_o  = res_q.ld_data;
    assign misalign_o = res_q.misalign;

    // R7
    misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> (wr_en_o == '0 && wr_data_o == '0 && ld_data_o == '0));

    // R3
    lane_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_o & ~lane_expand(wr_en_o)) == '0);

    // R2
    en_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o != '0) |-> $onehot($countones(wr_en_o)));
endmodule

// File: tb/tb_lane_aligner.sv
`timescale 1ns/1ps
module tb_lane_aligner;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] addr_i;
    logic [1:0]  size_i;
    logic        swap_i;
    logic        st_req_i;
    logic [63:0] st_data_i;
    logic [63:0] ld_word_i;
    logic [28:0] word_idx_o;
    logic [7:0]  wr_en_o;
    logic [63:0] wr_data_o;
    logic [63:0] ld_data_o;
    logic        misalign_o;

    int vectors = 0;
    int misses  = 0;

    always #4 clk = ~clk;

    lane_aligner dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .size_i(size_i),
        .swap_i(swap_i), .st_req_i(st_req_i), .st_data_i(st_data_i),
        .ld_word_i(ld_word_i), .word_idx_o(word_idx_o), .wr_en_o(wr_en_o),
        .wr_data_o(wr_data_o), .ld_data_o(ld_data_o), .misalign_o(misalign_o)
    );

    function automatic bit exp_mis(input logic [31:0] a, input logic [1:0] s);
        return (int'(a[2:0]) + (1 << s)) > 8;
    endfunction

    function automatic logic [7:0] exp_en(input logic [31:0] a, input logic [1:0] s, input logic st);
        logic [7:0] e = '0;
        int off = int'(a[2:0]);
        int n   = 1 << s;
        if (!st || exp_mis(a, s)) return '0;
        for (int b = 0; b < 8; b++) if (b >= off && b < off + n) e[b] = 1'b1;
        return e;
    endfunction

    function automatic logic [63:0] exp_wd(input logic [31:0] a, input logic [1:0] s,
                                           input logic sw, input logic st, input logic [63:0] d);
        logic [63:0] r = '0;
        logic [7:0]  e = exp_en(a, s, st);
        int off = int'(a[2:0]);
        int n   = 1 << s;
        for (int b = 0; b < 8; b++) begin
            if (e[b]) begin
                int k = b - off;
                int src = sw ? (n - 1 - k) : k;
                r[8*b +: 8] = d[8*src +: 8];
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_ld(input logic [31:0] a, input logic [1:0] s,
                                           input logic sw, input logic [63:0] w);
        logic [63:0] r = '0;
        int off = int'(a[2:0]);
        int n   = 1 << s;
        if (exp_mis(a, s)) return '0;
        for (int k = 0; k < n; k++) begin
            int src = sw ? (n - 1 - k) : k;
            r[8*k +: 8] = w[8*(off + src) +: 8];
        end
        return r;
    endfunction

    task automatic cmp(input string tag, input string fld, input logic [63:0] got, input logic [63:0] exp);
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h", tag, fld, got, exp);
        end
    endtask

    // Drives at a falling edge and samples at the next falling edge (one register stage, R9).
    task automatic apply(input logic [31:0] a, input logic [1:0] s, input logic sw, input logic st,
                         input logic [63:0] sd, input logic [63:0] lw, input string tag);
        addr_i = a; size_i = s; swap_i = sw; st_req_i = st; st_data_i = sd; ld_word_i = lw;
        @(negedge clk);
        vectors++;
        cmp({tag, " R1"}, "word_idx", 64'(word_idx_o), 64'(a >> 3));
        cmp({tag, " R2/R10"}, "wr_en", 64'(wr_en_o), 64'(exp_en(a, s, st)));
        cmp({tag, " R3/R4"}, "wr_data", wr_data_o, exp_wd(a, s, sw, st, sd));
        cmp({tag, " R5/R6"}, "ld_data", ld_data_o, exp_ld(a, s, sw, lw));
        cmp({tag, " R7"}, "misalign", 64'(misalign_o), 64'(exp_mis(a, s)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [63:0] merged;
        int unsigned seed_v;
        seed_v = $urandom(32'h1A2B3C4D);
        rst_n = 1'b0;
        addr_i = 32'hFFFF_FFF9; size_i = 2'b01; swap_i = 1'b1; st_req_i = 1'b1;
        st_data_i = '1; ld_word_i = '1;
        repeat (3) @(negedge clk);
        // R9: reset clears every output
        vectors++;
        cmp("R9 reset", "all", {word_idx_o, wr_en_o, misalign_o, 26'd0} | wr_data_o | ld_data_o, 64'd0);
        rst_n = 1'b1;

        // R3: byte 0xEE to address 0x9 lands in lane 1 of word 1
        apply(32'h9, lane_pkg::SZ_BYTE, 1'b0, 1'b1, 64'hEE, 64'hABCDEF0187654321, "R3 example");
        merged = 64'hABCDEF0187654321;
        for (int b = 0; b < 8; b++) if (wr_en_o[b]) merged[8*b +: 8] = wr_data_o[8*b +: 8];
        vectors++;
        cmp("R3 merge", "word", merged, 64'hABCDEF018765EE21);
        // R5: read the same byte back from the merged word
        apply(32'h9, lane_pkg::SZ_BYTE, 1'b0, 1'b0, 64'h0, merged, "R5 readback");
        vectors++;
        cmp("R5 readback", "value", ld_data_o, 64'hEE);
        // R4: 4-byte swapped store at offset 4
        apply(32'h104, lane_pkg::SZ_WORD, 1'b1, 1'b1, 64'hFFFF_FFFF_1122_3344, 64'h0, "R4 swap st");
        vectors++;
        cmp("R4 swap st", "value", wr_data_o, 64'h4433_2211_0000_0000);
        // R6: swapped 2-byte load at offset 6
        apply(32'h6, lane_pkg::SZ_HALF, 1'b1, 1'b0, 64'h0, 64'hA1B2_0000_0000_0000, "R6 swap ld");
        vectors++;
        cmp("R6 swap ld", "value", ld_data_o, 64'h0000_0000_0000_B2A1);
        // R8: full doubleword at offset 0, and edge-ending accesses
        apply(32'h0, lane_pkg::SZ_DWORD, 1'b0, 1'b1, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, "R8 dword");
        apply(32'h4, lane_pkg::SZ_WORD, 1'b0, 1'b1, 64'h55667788, 64'h1, "R8 edge word");
        apply(32'h7, lane_pkg::SZ_BYTE, 1'b1, 1'b1, 64'h99, 64'hC3 << 56, "R8 edge byte");
        // R7: crossing by one byte
        apply(32'h5, lane_pkg::SZ_WORD, 1'b0, 1'b1, 64'hDEADBEEF, '1, "R7 cross word");
        apply(32'h7, lane_pkg::SZ_HALF, 1'b1, 1'b1, 64'hBEEF, '1, "R7 cross half");
        apply(32'h1, lane_pkg::SZ_DWORD, 1'b0, 1'b1, '1, '1, "R7 cross dword");
        // R10: load only, enables and data stay quiet
        apply(32'h2, lane_pkg::SZ_HALF, 1'b0, 1'b0, '1, 64'h0000_0000_7788_0000, "R10 load only");
        // R9: output holds until the next rising edge
        addr_i = 32'h7FF8; #2;
        vectors++;
        cmp("R9 hold", "word_idx", 64'(word_idx_o), 64'(32'h2 >> 3));

        for (int i = 0; i < 400; i++) begin
            apply($urandom, 2'($urandom % 4), 1'($urandom), 1'($urandom),
                  {$urandom, $urandom}, {$urandom, $urandom}, "random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule